// File: doc/BRIEF.md
# Masked Fuse Row Read Unit

This block lets software read rows of a one-time-programmable fuse array while exposing only the columns it is cleared to see. Software writes a read address that names an array and a row. The unit decodes that address and decides whether the read is allowed. For an allowed read it fetches the 32-bit row through a row-read port, clears every column that is not permitted for that row, and latches the result in a read-data register. It then reports completion through a done bit and an error bit.

The fuse storage sits outside the block. A parameter selects a port that returns data in the same cycle or a port that returns it one cycle after the request. Array 1 is never readable. Arrays 2 and 3 are returned whole, but they sit one slot lower in the storage index, so the fetch uses the array number minus one. For array 0, a fixed column-visibility table chosen by row decides what survives.

Top module: `fuse_row_reader`

## Requirements
- R1: After reset, rd_data is 0 and both rd_done and rd_error are 0.
- R2: The array select is taken from address bits 12:11 and the row from bits 10:5. Address bits 4:0 have no effect on the result.
- R3: Array 0, row 0 returns only columns 31:28 of the fetched row. All other bits read as 0.
- R4: Array 0 rows 8 to 15, 20, 22, 23 and 40 to 63 return all 32 columns unchanged.
- R5: Array 0 row 16 keeps columns 7:0 and 16:10. Row 17 keeps columns 2:0. Row 21 keeps columns 23:0 and 31:29.
- R6: Array 0 rows that have no listed columns (1 to 7, 18, 19, 24 to 39) complete as granted reads that return 0.
- R7: Arrays 2 and 3 return the whole row. The fetch presents array index 1 or 2 respectively on fuse_rd_sel, with the row unchanged.
- R8: A read of array 1 is denied. It issues no fetch, sets rd_data to 0, sets rd_error and clears rd_done.
- R9: A granted read sets rd_done and clears rd_error. The two bits are never both 1.
- R10: The result appears FETCH_LAT+1 clock edges after the edge that samples addr_wr. rd_data then holds until a later address write completes.
- R11: Each granted read raises fuse_rd_en for exactly one cycle, the cycle right after the address write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_wr | input | 1 | Write strobe for the read address; starts a read |
| addr_wdata | input | 13 | Read address: array in 12:11, row in 10:5 |
| fuse_rd_en | output | 1 | Row fetch request to the fuse storage |
| fuse_rd_sel | output | 2 | Remapped array index for the fetch |
| fuse_rd_row | output | 6 | Row index for the fetch |
| fuse_rd_data | input | 32 | Row data from storage (same cycle or one cycle later) |
| rd_data | output | 32 | Masked read result |
| rd_done | output | 1 | Last read was granted |
| rd_error | output | 1 | Last read was denied |

## Verification
The bench reads rows whose visibility masks differ only in a few columns, such as rows 16, 17, 21 and 0. An off-by-one column range would then show up as a single flipped bit. It reads rows that have no listed mask, to catch a design that passes their data through or flags them as errors. It reads arrays 2 and 3 and checks the fetched array index, which catches a missing remap that would return the wrong array. It also reads array 1 right after a granted read, so a design that fetched anyway, kept stale data, or left done set would be caught. Junk in the low address bits and repeated sampling of a held result cover decoders that use too many bits and read-data that drifts after completion.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

   localparam int COL_N      = 32;
   localparam int TABLE_ROWS = 64;

   typedef logic [COL_N-1:0] col_mask_t;

   // columns lo..hi set, inclusive
   function automatic col_mask_t col_span(input int lo, input int hi);
      col_mask_t m;
      m = '0;
      for (int c = 0; c < COL_N; c++) begin
         if (c >= lo && c <= hi) m[c] = 1'b1;
      end
      return m;
   endfunction

   // visibility of array-0 rows; rows with no entry expose nothing
   function automatic col_mask_t bank0_row_mask(input int row);
      col_mask_t m;
      if (row == 0)                         m = col_span(28, 31);
      else if (row >= 8 && row <= 15)       m = '1;
      else if (row == 16)                   m = col_span(0, 7) | col_span(10, 16);
      else if (row == 17)                   m = col_span(0, 2);
      else if (row == 20)                   m = '1;
      else if (row == 21)                   m = col_span(0, 23) | col_span(29, 31);
      else if (row == 22 || row == 23)      m = '1;
      else if (row >= 40 && row <= 63)      m = '1;
      else                                  m = '0;
      return m;
   endfunction

endpackage

// File: rtl/fuse_rd_decode.sv
module fuse_rd_decode
   import fuse_rd_pkg::*;
#(
   parameter int ROW_LSB = 5,
   parameter int ROW_W   = 6,
   parameter int SEL_LSB = 11,
   parameter int SEL_W   = 2,
   localparam int ADDR_W = SEL_LSB + SEL_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_wr,
   input  logic [ADDR_W-1:0] addr_wdata,
   output logic              s1_valid,
   output logic              s1_grant,
   output col_mask_t         s1_mask,
   output logic [SEL_W-1:0]  s1_sel,
   output logic [ROW_W-1:0]  s1_row
);

   if (ROW_LSB < 1)                 $error("ROW_LSB must leave at least one ignored bit");
   if (SEL_LSB < ROW_LSB + ROW_W)   $error("array field overlaps row field");
   if (SEL_W != 2)                  $error("array select must be two bits");

   logic [SEL_W-1:0] arr;
   logic [ROW_W-1:0] row;
   logic             unused_low;
   logic             in_table;
   logic             grant_c;
   col_mask_t        mask_c;
   logic [SEL_W-1:0] sel_c;

   assign arr        = addr_wdata[SEL_LSB +: SEL_W];
   assign row        = addr_wdata[ROW_LSB +: ROW_W];
   assign unused_low = ^addr_wdata[ROW_LSB-1:0];

   // rows past the mask table are refused; a narrow row field never leaves it
   if ((1 << ROW_W) <= TABLE_ROWS) begin : g_tab_full
      assign in_table = 1'b1;
   end else begin : g_tab_cmp
      localparam logic [ROW_W-1:0] TAB_LIM = ROW_W'(TABLE_ROWS);
      assign in_table = (row < TAB_LIM);
   end

   always_comb begin
      grant_c = 1'b0;
      mask_c  = '0;
      sel_c   = arr;
      unique case (arr)
         2'd0: begin
            grant_c = in_table;
            mask_c  = bank0_row_mask(int'(row));
         end
         2'd1: begin
            grant_c = 1'b0;
         end
         default: begin
            grant_c = 1'b1;
            mask_c  = '1;
            sel_c   = arr - 2'd1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_grant <= 1'b0;
         s1_mask  <= '0;
         s1_sel   <= '0;
         s1_row   <= '0;
      end else begin
         s1_valid <= addr_wr;
         if (addr_wr) begin
            s1_grant <= grant_c;
            s1_mask  <= mask_c;
            s1_sel   <= sel_c;
            s1_row   <= row;
         end
      end
   end

   a_r8_array1_refused: assert property (@(posedge clk) disable iff (!rst_n)
      addr_wr && (arr == 2'd1) |=> s1_valid && !s1_grant);

   a_r7_upper_remap: assert property (@(posedge clk) disable iff (!rst_n)
      addr_wr && arr[1] |=> s1_grant && (s1_sel == $past(arr) - 2'd1));

endmodule

// File: rtl/fuse_rd_fetch.sv
module fuse_rd_fetch
   import fuse_rd_pkg::*;
#(
   parameter int FETCH_LAT = 1,
   parameter int ROW_W     = 6,
   parameter int SEL_W     = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_grant,
   input  col_mask_t        in_mask,
   input  logic [SEL_W-1:0] in_sel,
   input  logic [ROW_W-1:0] in_row,
   output logic             fuse_rd_en,
   output logic [SEL_W-1:0] fuse_rd_sel,
   output logic [ROW_W-1:0] fuse_rd_row,
   output logic             out_valid,
   output logic             out_grant,
   output col_mask_t        out_mask
);

   if (FETCH_LAT < 0 || FETCH_LAT > 1) $error("FETCH_LAT must be 0 or 1");

   assign fuse_rd_en  = in_valid & in_grant;
   assign fuse_rd_sel = in_sel;
   assign fuse_rd_row = in_row;

   if (FETCH_LAT == 0) begin : g_comb
      assign out_valid = in_valid;
      assign out_grant = in_grant;
      assign out_mask  = in_mask;
   end else begin : g_reg
      logic      v_q;
      logic      g_q;
      col_mask_t m_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            g_q <= 1'b0;
            m_q <= '0;
         end else begin
            v_q <= in_valid;
            if (in_valid) begin
               g_q <= in_grant;
               m_q <= in_mask;
            end
         end
      end
      assign out_valid = v_q;
      assign out_grant = g_q;
      assign out_mask  = m_q;

      a_r10_stage_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
   end

endmodule

// File: rtl/fuse_rd_commit.sv
module fuse_rd_commit
   import fuse_rd_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_grant,
   input  col_mask_t         in_mask,
   input  logic [DATA_W-1:0] row_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_done,
   output logic              rd_error
);

   if (DATA_W != COL_N) $error("data width must match the mask table width");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_done  <= 1'b0;
         rd_error <= 1'b0;
      end else if (in_valid) begin
         if (in_grant) begin
            rd_data  <= row_data & in_mask;
            rd_done  <= 1'b1;
            rd_error <= 1'b0;
         end else begin
            rd_data  <= '0;
            rd_done  <= 1'b0;
            rd_error <= 1'b1;
         end
      end
   end

   a_r9_grant_status: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_grant |=> rd_done && !rd_error);

   a_r8_deny_status: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_grant |=> (rd_data == '0) && rd_error && !rd_done);

   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_done && rd_error));

   a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(rd_data) && $stable(rd_done) && $stable(rd_error));

endmodule

// File: rtl/fuse_row_reader.sv
module fuse_row_reader
   import fuse_rd_pkg::*;
#(
   parameter int FETCH_LAT = 1,
   parameter int DATA_W    = 32,
   parameter int ROW_LSB   = 5,
   parameter int ROW_W     = 6,
   parameter int SEL_LSB   = 11,
   parameter int SEL_W     = 2,
   localparam int ADDR_W   = SEL_LSB + SEL_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_wr,
   input  logic [ADDR_W-1:0] addr_wdata,
   output logic              fuse_rd_en,
   output logic [SEL_W-1:0]  fuse_rd_sel,
   output logic [ROW_W-1:0]  fuse_rd_row,
   input  logic [DATA_W-1:0] fuse_rd_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_done,
   output logic              rd_error
);

   logic             s1_valid, s1_grant;
   col_mask_t        s1_mask;
   logic [SEL_W-1:0] s1_sel;
   logic [ROW_W-1:0] s1_row;
   logic             s2_valid, s2_grant;
   col_mask_t        s2_mask;

   fuse_rd_decode #(
      .ROW_LSB(ROW_LSB), .ROW_W(ROW_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)
   ) u_decode (
      .clk(clk), .rst_n(rst_n),
      .addr_wr(addr_wr), .addr_wdata(addr_wdata),
      .s1_valid(s1_valid), .s1_grant(s1_grant), .s1_mask(s1_mask),
      .s1_sel(s1_sel), .s1_row(s1_row)
   );

   fuse_rd_fetch #(
      .FETCH_LAT(FETCH_LAT), .ROW_W(ROW_W), .SEL_W(SEL_W)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .in_valid(s1_valid), .in_grant(s1_grant), .in_mask(s1_mask),
      .in_sel(s1_sel), .in_row(s1_row),
      .fuse_rd_en(fuse_rd_en), .fuse_rd_sel(fuse_rd_sel), .fuse_rd_row(fuse_rd_row),
      .out_valid(s2_valid), .out_grant(s2_grant), .out_mask(s2_mask)
   );

   fuse_rd_commit #(
      .DATA_W(DATA_W)
   ) u_commit (
      .clk(clk), .rst_n(rst_n),
      .in_valid(s2_valid), .in_grant(s2_grant), .in_mask(s2_mask),
      .row_data(fuse_rd_data),
      .rd_data(rd_data), .rd_done(rd_done), .rd_error(rd_error)
   );

   a_r11_fetch_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_rd_en |-> $past(addr_wr));

   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_rd_en && !addr_wr |=> !fuse_rd_en);

   a_r7_no_raw_top_array: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_rd_en |-> (fuse_rd_sel != 2'd3));

endmodule

// File: tb/sim_fuse_row_reader.sv
`timescale 1ns/1ps
module sim_fuse_row_reader;

   localparam int LAT = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_wr = 1'b0;
   logic [12:0] addr_wdata = '0;
   logic        fuse_rd_en;
   logic [1:0]  fuse_rd_sel;
   logic [5:0]  fuse_rd_row;
   logic [31:0] fuse_rd_data;
   logic [31:0] rd_data;
   logic        rd_done, rd_error;

   int n_run  = 0;
   int n_fail = 0;
   int n_fetch = 0;
   logic [1:0] seen_sel = '0;
   logic [5:0] seen_row = '0;

   always #2.5 clk = ~clk;

   fuse_row_reader #(.FETCH_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
      .fuse_rd_en(fuse_rd_en), .fuse_rd_sel(fuse_rd_sel), .fuse_rd_row(fuse_rd_row),
      .fuse_rd_data(fuse_rd_data), .rd_data(rd_data), .rd_done(rd_done), .rd_error(rd_error)
   );

   // fuse storage model: distinct contents per (index,row)
   function automatic logic [31:0] pat(input logic [1:0] s, input logic [5:0] r);
      logic [31:0] k;
      k = {24'd0, s, r} + 32'd1;
      return (k * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
   endfunction

   if (LAT == 0) begin : g_fz
      assign fuse_rd_data = pat(fuse_rd_sel, fuse_rd_row);
   end else begin : g_fr
      logic [31:0] q = '0;
      always @(posedge clk) if (fuse_rd_en) q <= pat(fuse_rd_sel, fuse_rd_row);
      assign fuse_rd_data = q;
   end

   always @(posedge clk) if (rst_n && fuse_rd_en) begin
      n_fetch  <= n_fetch + 1;
      seen_sel <= fuse_rd_sel;
      seen_row <= fuse_rd_row;
   end

   // expected visibility, written from the requirement list
   function automatic logic [31:0] vis(input int r);
      if (r == 0)  return 32'hF000_0000;                    // R3
      if (r == 16) return 32'h0001_FCFF;                    // R5
      if (r == 17) return 32'h0000_0007;                    // R5
      if (r == 21) return 32'hE0FF_FFFF;                    // R5
      if ((r >= 8 && r <= 15) || r == 20 || r == 22 || r == 23 || r >= 40)
         return 32'hFFFF_FFFF;                              // R4
      return 32'h0;                                         // R6
   endfunction

   typedef struct {
      string       req;
      logic [31:0] data;
      logic        done;
      logic        err;
      logic        fetch;
      logic [1:0]  sel;
      logic [5:0]  row;
   } exp_t;

   exp_t q[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_read(input string req, input int arr, input int row, input logic [4:0] junk);
      exp_t e;
      e.req = req;
      e.row = 6'(row);
      if (arr == 1) begin
         e.data = '0; e.done = 0; e.err = 1; e.fetch = 0; e.sel = '0;
      end else begin
         e.sel   = (arr == 0) ? 2'd0 : 2'(arr - 1);
         e.data  = pat(e.sel, e.row) & ((arr == 0) ? vis(row) : 32'hFFFF_FFFF);
         e.done  = 1; e.err = 0; e.fetch = 1;
      end
      @(negedge clk);
      q.push_back(e);
      addr_wr    = 1'b1;
      addr_wdata = {2'(arr), 6'(row), junk};
      @(negedge clk);
      addr_wr    = 1'b0;
      addr_wdata = '0;
      wait (q.size() == 0);
   endtask

   // monitor: pops expectations and compares at the completion cycle
   initial begin
      forever begin
         exp_t e;
         int f0;
         wait (q.size() > 0);
         f0 = n_fetch;
         repeat (LAT + 2) @(posedge clk);
         #1;
         e = q[0];
         chk({e.req, " data"},  rd_data, e.data);
         chk({e.req, " done"},  {31'd0, rd_done}, {31'd0, e.done});
         chk({e.req, " error"}, {31'd0, rd_error}, {31'd0, e.err});
         chk({e.req, " R11 fetch count"}, 32'(n_fetch - f0), {31'd0, e.fetch});
         if (e.fetch) chk({e.req, " R7 fetch addr"}, {24'd0, seen_sel, seen_row}, {24'd0, e.sel, e.row});
         void'(q.pop_front());
      end
   end

   initial begin
      #(5.0 * 200000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset data", rd_data, 32'h0);
      chk("R1 reset done", {31'd0, rd_done}, 32'h0);
      chk("R1 reset error", {31'd0, rd_error}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      do_read("R3 a0 r0", 0, 0, 5'd0);
      do_read("R4 a0 r8", 0, 8, 5'd0);
      do_read("R4 a0 r15", 0, 15, 5'd0);
      do_read("R4 a0 r20", 0, 20, 5'd0);
      do_read("R4 a0 r22", 0, 22, 5'd0);
      do_read("R4 a0 r23", 0, 23, 5'd0);
      do_read("R4 a0 r40", 0, 40, 5'd0);
      do_read("R9 a0 r63", 0, 63, 5'd0);
      do_read("R5 a0 r16", 0, 16, 5'd0);
      do_read("R5 a0 r17", 0, 17, 5'd0);
      do_read("R5 a0 r21", 0, 21, 5'd0);
      do_read("R6 a0 r1", 0, 1, 5'd0);
      do_read("R6 a0 r7", 0, 7, 5'd0);
      do_read("R6 a0 r19", 0, 19, 5'd0);
      do_read("R6 a0 r33", 0, 33, 5'd0);
      do_read("R7 a2 r5", 2, 5, 5'd0);
      do_read("R7 a3 r63", 3, 63, 5'd0);
      do_read("R8 a1 r8", 1, 8, 5'd0);
      do_read("R9 a3 r0 after deny", 3, 0, 5'd0);
      do_read("R8 a1 r0 after grant", 1, 0, 5'd0);
      do_read("R2 a0 r16 junk", 0, 16, 5'h1F);
      do_read("R2 a2 r9 junk", 2, 9, 5'h15);

      // R10: result held while no further write arrives
      do_read("R10 a0 r21", 0, 21, 5'd0);
      repeat (6) @(negedge clk);
      chk("R10 hold data", rd_data, pat(2'd0, 6'd21) & 32'hE0FF_FFFF);
      chk("R10 hold done", {31'd0, rd_done}, 32'h1);

      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule